// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is a 32-pin general-purpose I/O port placed behind a simple single-word register bus. Software sets each pin as an input or an output. It writes the data register to drive the output pins and reads the same register to see the sampled input pins. An open-drain flag is kept for each pin and passed out to the pad logic.

Each input pin passes through a synchronizer and then an edge detector. An edge on an input pin latches a pending event bit. A control bit for each pin chooses whether any transition counts as an event or only a high-to-low transition. Software clears pending events by writing ones to them. A single interrupt line stays high while any pending event is also enabled in the mask register.

Every register uses reversed bit order. Pin n sits at register bit 31-n, so pin 0 is the most significant bit.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, all six registers read zero. `irq`, `pin_out`, `pin_oe` and `pin_od` are all zero.
- R2: The registers are at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 control. A word written to direction, open-drain, mask or control reads back unchanged. Direction also appears on `pin_oe` and open-drain on `pin_od`.
- R3: Pin n corresponds to register bit 31-n in every register. For example, `pin_oe[0]` follows direction bit 31.
- R4: A request takes effect only when `bus_size` is 2'b10 (a full word). A read of any other size returns zero. A write of any other size changes no register.
- R5: A read of any offset other than the six listed returns zero. Unaligned offsets such as 0x02 count as unlisted. A write to such an offset changes no register.
- R6: `bus_ready` is high in the cycle after every request, and `bus_rdata` is valid in that cycle.
- R7: A word write to data loads the written bit onto `pin_out` for every pin whose direction bit is 1. `pin_out` of a pin whose direction bit is 0 keeps its last value.
- R8: The data bit of an input pin (direction 0) shows the pin level three clock edges after the change. Level changes on an output pin alter neither its data bit nor its event bit.
- R9: On an input pin with control bit 0, any level change sets its event bit. With control bit 1, only a high-to-low change sets it.
- R10: A word written to the event register clears each bit written as 1. Bits written as 0 are left unchanged.
- R11: If an edge sets an event bit in the same cycle that a write-one-to-clear targets that bit, the bit ends up set.
- R12: `irq` is high exactly when the bitwise AND of the event and mask registers is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size; 2'b10 = full word |
| bus_addr | input | ADDR_W (12) | Byte offset |
| bus_wdata | input | NUM_PINS (32) | Write data |
| bus_rdata | output | NUM_PINS (32) | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after request |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels, index = pin number |
| pin_out | output | NUM_PINS (32) | Driven output levels, index = pin number |
| pin_oe | output | NUM_PINS (32) | Pin is an output, index = pin number |
| pin_od | output | NUM_PINS (32) | Open-drain flag, index = pin number |
| irq | output | 1 | Pending unmasked event |

## Verification
The bench walks a single raised input across all 32 pins, one at a time. Each step reads back both data and event. This separates a correct bit reversal from a shifted or unreversed mapping, and any-edge detection from rising-only detection.

Output behaviour is checked with complementary data patterns and with a split direction word. Together these show that only pins set as outputs follow a data write.

Separate cases check the following:
- falling-only mode rejects a rising edge;
- an edge on an output pin is ignored;
- a partial clear keeps its neighbouring events;
- an edge that meets a clear in the same cycle survives;
- `irq` follows the mask.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_ODR  = 3'd1,
        SEL_DAT  = 3'd2,
        SEL_EVT  = 3'd3,
        SEL_MSK  = 3'd4,
        SEL_CTL  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [31:0] OFF_DIR = 32'h00;
    localparam logic [31:0] OFF_ODR = 32'h04;
    localparam logic [31:0] OFF_DAT = 32'h08;
    localparam logic [31:0] OFF_EVT = 32'h0C;
    localparam logic [31:0] OFF_MSK = 32'h10;
    localparam logic [31:0] OFF_CTL = 32'h14;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    // Map a zero-extended byte offset onto a register selector.
    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        reg_sel_e s;
        case (off)
            OFF_DIR: s = SEL_DIR;
            OFF_ODR: s = SEL_ODR;
            OFF_DAT: s = SEL_DAT;
            OFF_EVT: s = SEL_EVT;
            OFF_MSK: s = SEL_MSK;
            OFF_CTL: s = SEL_CTL;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,      // synchronized level, register bit order
    input  logic [W-1:0] dir,      // 1 = output
    input  logic [W-1:0] fall_only,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] prev_q;
    logic [W-1:0] changed;
    logic [W-1:0] fell;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign changed = lvl ^ prev_q;
    assign fell    = prev_q & ~lvl;
    assign set_vec = ~dir & ((~fall_only & changed) | (fall_only & fell));

    // R9: an event request only ever follows a real level change
    a_r9_needs_change: assert property (@(posedge clk) disable iff (rst)
        (set_vec & ~(lvl ^ $past(lvl))) == '0);

    // R9: in falling-only mode no request is raised while the level is high
    a_r9_fall_mode_low: assert property (@(posedge clk) disable iff (rst)
        (set_vec & fall_only & lvl) == '0);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_edge_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              bus_ready,
    input  logic [W-1:0]      lvl,
    input  logic [W-1:0]      set_vec,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      odr_q,
    output logic [W-1:0]      ctl_q,
    output logic [W-1:0]      out_q,
    output logic              irq
);
    logic [W-1:0] dat_q, evt_q, msk_q;
    logic [W-1:0] clr_vec, dat_nxt, rd_mux;
    bus_op_t      op;

    always_comb begin
        op.wr  = bus_req &  bus_we & (bus_size == SIZE_WORD);
        op.rd  = bus_req & ~bus_we & (bus_size == SIZE_WORD);
        op.sel = decode_offset(32'(bus_addr));
    end

    assign clr_vec = (op.wr && op.sel == SEL_EVT) ? bus_wdata : '0;
    assign dat_nxt = (dir_q & ((op.wr && op.sel == SEL_DAT) ? bus_wdata : dat_q))
                   | (~dir_q & lvl);

    always_comb begin
        case (op.sel)
            SEL_DIR: rd_mux = dir_q;
            SEL_ODR: rd_mux = odr_q;
            SEL_DAT: rd_mux = dat_q;
            SEL_EVT: rd_mux = evt_q;
            SEL_MSK: rd_mux = msk_q;
            SEL_CTL: rd_mux = ctl_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '0;
            odr_q     <= '0;
            dat_q     <= '0;
            evt_q     <= '0;
            msk_q     <= '0;
            ctl_q     <= '0;
            out_q     <= '0;
            bus_rdata <= '0;
            bus_ready <= 1'b0;
        end else begin
            bus_ready <= bus_req;
            bus_rdata <= op.rd ? rd_mux : '0;
            if (op.wr && op.sel == SEL_DIR) dir_q <= bus_wdata;
            if (op.wr && op.sel == SEL_ODR) odr_q <= bus_wdata;
            if (op.wr && op.sel == SEL_MSK) msk_q <= bus_wdata;
            if (op.wr && op.sel == SEL_CTL) ctl_q <= bus_wdata;
            if (op.wr && op.sel == SEL_DAT) out_q <= (dir_q & bus_wdata) | (~dir_q & out_q);
            dat_q <= dat_nxt;
            evt_q <= (evt_q & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(evt_q & msk_q);

    a_r6_ready_follows_req: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ready);

    a_r4_partial_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_size != SIZE_WORD) |=>
            ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

    a_r10_uncleared_stay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_q & $past(evt_q & ~clr_vec)) == $past(evt_q & ~clr_vec)));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_q & $past(set_vec)) == $past(set_vec)));

    a_r8_output_no_event: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((evt_q & ~$past(evt_q)) & $past(dir_q)) == '0));

    a_r12_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (msk_q == '0) |-> !irq);

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                bus_ready,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_od,
    output logic                irq
);
    localparam int TOP_BIT = NUM_PINS - 1;

    logic [NUM_PINS-1:0] in_regord, lvl_regord, set_vec;
    logic [NUM_PINS-1:0] dir_q, odr_q, ctl_q, out_q;

    // pin n <-> register bit TOP_BIT-n
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pinmap
        assign in_regord[TOP_BIT-n] = pin_in[n];
        assign pin_out[n]           = out_q[TOP_BIT-n];
        assign pin_oe[n]            = dir_q[TOP_BIT-n];
        assign pin_od[n]            = odr_q[TOP_BIT-n];
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (in_regord),
        .q_sync  (lvl_regord)
    );

    gpio_edge_detect #(.W(NUM_PINS)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl_regord),
        .dir       (dir_q),
        .fall_only (ctl_q),
        .set_vec   (set_vec)
    );

    gpio_regfile #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .lvl       (lvl_regord),
        .set_vec   (set_vec),
        .dir_q     (dir_q),
        .odr_q     (odr_q),
        .ctl_q     (ctl_q),
        .out_q     (out_q),
        .irq       (irq)
    );

endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_DIR = 12'h00, A_ODR = 12'h04, A_DAT = 12'h08,
                            A_EVT = 12'h0C, A_MSK = 12'h10, A_CTL = 12'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ready;
    logic [31:0] pin_in = '0, pin_out, pin_oe, pin_od;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .irq(irq)
    );

    function automatic logic [31:0] rbit(input int n);
        return 32'h8000_0000 >> n;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'b10;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [1:0] sz = 2'b10);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(posedge clk); @(negedge clk);
        check("R6 ready", {31'd0, bus_ready}, 32'd1);
        d = bus_rdata;
        bus_req = 1'b0; bus_size = 2'b10;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_DIR, v); check("R1 dir", v, 0);
        rd(A_ODR, v); check("R1 odr", v, 0);
        rd(A_DAT, v); check("R1 dat", v, 0);
        rd(A_EVT, v); check("R1 evt", v, 0);
        rd(A_MSK, v); check("R1 msk", v, 0);
        rd(A_CTL, v); check("R1 ctl", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 pins", pin_out | pin_oe | pin_od, 0);

        // R2 readback and R3 exported mapping
        wr(A_ODR, 32'hA5C3_0F01); rd(A_ODR, v); check("R2 odr", v, 32'hA5C3_0F01);
        check("R3 pin_od", pin_od, rev(32'hA5C3_0F01));
        wr(A_MSK, 32'h1234_5678); rd(A_MSK, v); check("R2 msk", v, 32'h1234_5678);
        wr(A_CTL, 32'h0F0F_F0F0); rd(A_CTL, v); check("R2 ctl", v, 32'h0F0F_F0F0);
        wr(A_DIR, 32'h8000_0001); rd(A_DIR, v); check("R2 dir", v, 32'h8000_0001);
        check("R3 pin_oe", pin_oe, 32'h8000_0001);

        // R4 partial size
        wr(A_MSK, 32'hFFFF_FFFF, 2'b00); rd(A_MSK, v); check("R4 byte write", v, 32'h1234_5678);
        wr(A_CTL, 32'h0, 2'b01);         rd(A_CTL, v); check("R4 half write", v, 32'h0F0F_F0F0);
        rd(A_MSK, v, 2'b00); check("R4 byte read", v, 0);
        rd(A_ODR, v, 2'b11); check("R4 reserved read", v, 0);

        // R5 unmapped
        wr(12'h018, 32'hFFFF_FFFF); wr(12'h002, 32'hFFFF_FFFF);
        rd(12'h018, v); check("R5 read 0x18", v, 0);
        rd(12'h006, v); check("R5 read 0x06", v, 0);
        rd(A_MSK, v); check("R5 msk kept", v, 32'h1234_5678);
        rd(A_DIR, v); check("R5 dir kept", v, 32'h8000_0001);

        // R7 outputs
        wr(A_MSK, 0); wr(A_CTL, 0); wr(A_ODR, 0);
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_DAT, 32'hC0FF_EE11); check("R7 out A", pin_out, rev(32'hC0FF_EE11));
        wr(A_DAT, 32'h3F00_11EE); check("R7 out B", pin_out, rev(32'h3F00_11EE));
        wr(A_DIR, 32'hFFFF_0000);
        wr(A_DAT, 32'h0000_FFFF);
        check("R7 split", pin_out, rev(32'h0000_11EE));
        rd(A_DAT, v); check("R7 dat readback", v, 32'h0000_0000);

        // R3/R8/R9 sweep: any-edge, one pin at a time
        wr(A_DIR, 0); wr(A_EVT, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            pin_in = 32'd1 << n; settle();
            rd(A_DAT, v); check($sformatf("R3 R8 dat pin%0d", n), v, rbit(n));
            rd(A_EVT, v); check($sformatf("R9 rise pin%0d", n), v, rbit(n));
            wr(A_EVT, 32'hFFFF_FFFF);
            pin_in = 0; settle();
            rd(A_EVT, v); check($sformatf("R9 fall pin%0d", n), v, rbit(n));
            wr(A_EVT, 32'hFFFF_FFFF);
        end

        // R9 falling-only mode on pin 4
        wr(A_CTL, rbit(4));
        pin_in = 32'd1 << 4; settle();
        rd(A_EVT, v); check("R9 fall-only rising ignored", v, 0);
        pin_in = 0; settle();
        rd(A_EVT, v); check("R9 fall-only falling", v, rbit(4));
        wr(A_EVT, 32'hFFFF_FFFF); wr(A_CTL, 0);

        // R8 output pin ignores input changes
        wr(A_DIR, rbit(6)); wr(A_DAT, rbit(6));
        pin_in = 32'd1 << 6; settle(); pin_in = 0; settle();
        rd(A_EVT, v); check("R8 output no event", v, 0);
        rd(A_DAT, v); check("R8 output data kept", v, rbit(6));
        wr(A_DIR, 0); wr(A_EVT, 32'hFFFF_FFFF);

        // R10 selective clear
        pin_in = (32'd1 << 1) | (32'd1 << 2); settle();
        rd(A_EVT, v); check("R10 both set", v, rbit(1) | rbit(2));
        wr(A_EVT, rbit(1));
        rd(A_EVT, v); check("R10 partial clear", v, rbit(2));

        // R12 interrupt follows mask
        check("R12 irq unmasked off", {31'd0, irq}, 0);
        wr(A_MSK, rbit(2)); check("R12 irq on", {31'd0, irq}, 1);
        wr(A_MSK, rbit(1)); check("R12 irq other mask", {31'd0, irq}, 0);
        wr(A_MSK, rbit(2)); wr(A_EVT, rbit(2)); check("R12 irq after clear", {31'd0, irq}, 0);
        wr(A_MSK, 0);

        // R11 set and clear in the same cycle (pin 9)
        wr(A_EVT, 32'hFFFF_FFFF);
        pin_in[9] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr(A_EVT, rbit(9));
        rd(A_EVT, v); check("R11 set wins", v, rbit(9));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule